// File: doc/BRIEF.md
# RMII Transmit Dibit Serializer

This block is the transmit back end of a MAC facing a reduced media-independent interface. Frame bytes arrive from upstream logic over a valid/ready handshake, with a marker on the final byte. The block opens each frame with a configurable run of preamble bytes (0x55) and a start-of-frame delimiter byte (0xD5). It then sends the preamble, the delimiter and the payload to the PHY two bits per reference-clock cycle on a dibit bus, with a transmit-enable qualifier.

The enable rises on the cycle that carries the first preamble dibit. It stays high for every dibit of the frame and falls on the cycle right after the last one. The dibit bus carries 00 whenever the enable is low. After each frame, a gap timer holds back the next frame until a minimum number of idle clocks has passed. If upstream fails to supply a byte when one is requested, the frame is cut off at the current byte boundary and a one-cycle underrun flag is raised.

Frame check sequence generation, padding, collision retries and the 10 Mb/s clocking mode are handled elsewhere. The upstream logic must append the check sequence and any pad bytes before handing the bytes over.

Top module: `rmii_tx_serializer`

## Requirements
- R1: While reset is held and in the first idle cycle after it, tx_en is 0, txd is 00, in_ready is 0 and underrun is 0.
- R2: A frame opens with PRE_LEN bytes of 0x55 followed by one byte 0xD5, each byte sent least-significant dibit first (byte bits [1:0] on the first cycle, [7:6] on the fourth), and tx_en is high on the cycle carrying the first preamble dibit.
- R3: The payload bytes follow the delimiter in the order they were accepted, four dibits each, least-significant first. tx_en stays high without a break for exactly 4*(PRE_LEN+1+N) cycles for an N-byte frame, ending with the fourth dibit of the byte accepted with in_last=1.
- R4: On every cycle where tx_en is 0, txd is 00, whatever values in_data, in_last and in_valid carry.
- R5: in_ready is 1 only on the fourth dibit of the delimiter and on the fourth dibit of each payload byte that was not marked last. It is 0 throughout the preamble, the first three dibits of every byte and while idle. A byte is taken on the clock edge where in_valid and in_ready are both 1.
- R6: After tx_en falls, it stays low for at least GAP_CLOCKS cycles. When the next frame is already pending, it rises again after exactly GAP_CLOCKS low cycles.
- R7: With the gap satisfied (including directly after reset), the clock edge that samples in_valid=1 while idle starts the frame, so tx_en is 1 on the next cycle. No frame starts while in_valid is 0.
- R8: If in_valid is 0 while in_ready is 1, the byte currently being sent is the frame's last, tx_en falls right after its fourth dibit, and underrun is 1 for exactly one cycle: the first cycle with tx_en low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all outputs change on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8 | Frame byte from upstream |
| in_valid | input | 1 | in_data holds a byte of the current or next frame |
| in_last | input | 1 | in_data is the final byte of its frame |
| in_ready | output | 1 | The byte on in_data is taken at the next rising edge if in_valid is 1 |
| txd | output | 2 | Transmit dibit to the PHY, 00 when idle |
| tx_en | output | 1 | Transmit enable qualifying txd |
| underrun | output | 1 | One-cycle pulse after a frame truncated for lack of data |

## Verification
The bench builds the block with PRE_LEN=3 and GAP_CLOCKS=6. With these values a frame costs only a few dozen cycles, so the bench can sweep every payload length from 1 to 12 back to back and truncate a five-byte frame at every possible byte position, including on the delimiter itself. The short gap puts the exact inter-frame spacing and the restart latency within reach on every frame. Every cycle of every frame is compared against a dibit stream that the bench computes from the payload formula, along with the ready pattern that stream implies.

// File: rtl/rmii_tx_pkg.sv
// Package: rmii_tx_pkg
// Shared state encoding and fixed frame-opening byte values for the RMII
// transmit serializer. Assumes an 8-bit byte split into four dibits.
package rmii_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_SFD  = 2'd2,
        ST_DATA = 2'd3
    } tx_state_e;

    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;
    localparam logic [1:0] LAST_DIBIT = 2'd3;

endpackage

// File: rtl/rmii_tx_gap_timer.sv
// Module: rmii_tx_gap_timer
// Counts reference-clock cycles with the transmit enable low and reports
// when GAP_CLOCKS of them have elapsed (counting the current cycle), so a
// new frame may begin on the next edge. Starts out already open after reset.
// Assumes GAP_CLOCKS >= 1.
module rmii_tx_gap_timer #(
    parameter int GAP_CLOCKS = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    output logic gap_open
);
    localparam int GW = (GAP_CLOCKS > 1) ? $clog2(GAP_CLOCKS) : 1;
    localparam logic [GW-1:0] GAP_TOP = GW'(GAP_CLOCKS - 1);

    logic [GW-1:0] idle_cnt;

    // Restart on every enabled cycle, count idle cycles, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= GAP_TOP;
        end else if (tx_en) begin
            idle_cnt <= '0;
        end else if (idle_cnt != GAP_TOP) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    // Open once the current idle cycle is the last one the gap needs.
    always_comb gap_open = (idle_cnt == GAP_TOP);

endmodule

// File: rtl/rmii_tx_sequencer.sv
// Module: rmii_tx_sequencer
// Frame sequencer: walks preamble, delimiter and payload bytes, tracks the
// dibit index inside the current byte, fetches upstream bytes on the last
// dibit of the delimiter and of each non-final payload byte, and cuts the
// frame short with an underrun pulse when no byte is offered then.
// Assumes PRE_LEN >= 1 and that gap_open comes from an idle-cycle timer.
module rmii_tx_sequencer
    import rmii_tx_pkg::*;
#(
    parameter int PRE_LEN = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    input  logic       gap_open,
    output logic       in_ready,
    output logic       frame_on,
    output logic [7:0] cur_byte,
    output logic [1:0] dibit_idx,
    output logic       underrun
);
    localparam int BCW = (PRE_LEN > 1) ? $clog2(PRE_LEN) : 1;
    localparam logic [BCW-1:0] PRE_TOP = BCW'(PRE_LEN - 1);

    tx_state_e      state_q, state_d;
    logic [BCW-1:0] pre_cnt_q, pre_cnt_d;
    logic [7:0]     byte_q, byte_d;
    logic [1:0]     idx_q, idx_d;
    logic           last_q, last_d;
    logic           under_d;
    logic           byte_end;
    logic           take;

    // Upstream handshake: request only on the final dibit of the delimiter or of a non-final payload byte.
    always_comb begin
        byte_end = (idx_q == LAST_DIBIT);
        in_ready = byte_end &&
                   ((state_q == ST_SFD) || ((state_q == ST_DATA) && !last_q));
        take     = in_ready && in_valid;
    end

    // Next-state logic for state, byte counter, current byte and dibit index.
    always_comb begin
        state_d   = state_q;
        pre_cnt_d = pre_cnt_q;
        byte_d    = byte_q;
        idx_d     = idx_q;
        last_d    = last_q;
        under_d   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && gap_open) begin
                    state_d   = ST_PRE;
                    pre_cnt_d = '0;
                    byte_d    = PRE_BYTE;
                    idx_d     = '0;
                    last_d    = 1'b0;
                end
            end
            ST_PRE: begin
                idx_d = idx_q + 1'b1;
                if (byte_end) begin
                    if (pre_cnt_q == PRE_TOP) begin
                        state_d = ST_SFD;
                        byte_d  = SFD_BYTE;
                    end else begin
                        pre_cnt_d = pre_cnt_q + 1'b1;
                    end
                end
            end
            ST_SFD, ST_DATA: begin
                idx_d = idx_q + 1'b1;
                if (byte_end) begin
                    if ((state_q == ST_DATA) && last_q) begin
                        state_d = ST_IDLE;
                    end else if (take) begin
                        state_d = ST_DATA;
                        byte_d  = in_data;
                        last_d  = in_last;
                    end else begin
                        state_d = ST_IDLE;
                        under_d = 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pre_cnt_q <= '0;
            byte_q    <= '0;
            idx_q     <= '0;
            last_q    <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            state_q   <= state_d;
            pre_cnt_q <= pre_cnt_d;
            byte_q    <= byte_d;
            idx_q     <= idx_d;
            last_q    <= last_d;
            underrun  <= under_d;
        end
    end

    // Expose the registered frame context to the dibit driver.
    always_comb begin
        frame_on  = (state_q != ST_IDLE);
        cur_byte  = byte_q;
        dibit_idx = idx_q;
    end

endmodule

// File: rtl/rmii_tx_dibit_out.sv
// Module: rmii_tx_dibit_out
// Selects the dibit of the current byte named by the index, least
// significant pair at index 0, and forces 00 while the frame is off.
// Assumes all inputs come straight from registers, so the outputs only
// move on clock edges.
module rmii_tx_dibit_out (
    input  logic       frame_on,
    input  logic [7:0] cur_byte,
    input  logic [1:0] dibit_idx,
    output logic [1:0] txd,
    output logic       tx_en
);
    logic [1:0] pick;

    // Pick the addressed bit pair of the current byte.
    always_comb begin
        unique case (dibit_idx)
            2'd0:    pick = cur_byte[1:0];
            2'd1:    pick = cur_byte[3:2];
            2'd2:    pick = cur_byte[5:4];
            default: pick = cur_byte[7:6];
        endcase
    end

    // Qualify the pair with the enable; idle code is 00.
    always_comb begin
        tx_en = frame_on;
        txd   = frame_on ? pick : 2'b00;
    end

endmodule

// File: rtl/rmii_tx_serializer.sv
// Module: rmii_tx_serializer
// Top of the RMII transmit dibit serializer: sequencer, idle-gap timer and
// dibit driver. Takes bytes through valid/ready with a last marker, adds
// preamble and delimiter, sends two bits per clock with an enable, and
// spaces frames by at least GAP_CLOCKS idle cycles.
// Assumes clk is the 50 MHz reference clock shared with the PHY.
module rmii_tx_serializer #(
    parameter int PRE_LEN    = 7,
    parameter int GAP_CLOCKS = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    output logic [1:0] txd,
    output logic       tx_en,
    output logic       underrun
);
    logic       gap_open;
    logic       frame_on;
    logic [7:0] cur_byte;
    logic [1:0] dibit_idx;

    rmii_tx_sequencer #(
        .PRE_LEN(PRE_LEN)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_last  (in_last),
        .gap_open (gap_open),
        .in_ready (in_ready),
        .frame_on (frame_on),
        .cur_byte (cur_byte),
        .dibit_idx(dibit_idx),
        .underrun (underrun)
    );

    rmii_tx_gap_timer #(
        .GAP_CLOCKS(GAP_CLOCKS)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .gap_open(gap_open)
    );

    rmii_tx_dibit_out u_out (
        .frame_on (frame_on),
        .cur_byte (cur_byte),
        .dibit_idx(dibit_idx),
        .txd      (txd),
        .tx_en    (tx_en)
    );

endmodule

// File: rtl/rmii_tx_checker.sv
// Module: rmii_tx_checker
// Port-level temporal checks for rmii_tx_serializer, attached by bind.
// Keeps its own idle-cycle counter to check the inter-frame gap.
module rmii_tx_checker #(
    parameter int GAP_CLOCKS = 48
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] txd,
    input logic       tx_en,
    input logic       in_ready,
    input logic       underrun
);
    localparam int CW = $clog2(GAP_CLOCKS + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(GAP_CLOCKS);

    logic [CW-1:0] low_cnt;

    // Count low-enable cycles since the last enabled cycle, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= CNT_TOP;
        end else if (tx_en) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_TOP) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // R4
    idle_code_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (txd == 2'b00));

    // R2
    first_dibit_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (txd == 2'b01));

    // R5
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx_en);

    // R6
    min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (low_cnt >= CNT_TOP));

    // R8
    underrun_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> (!tx_en && $past(tx_en)));

    // R8
    underrun_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

endmodule

bind rmii_tx_serializer rmii_tx_checker #(
    .GAP_CLOCKS(GAP_CLOCKS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .txd     (txd),
    .tx_en   (tx_en),
    .in_ready(in_ready),
    .underrun(underrun)
);

// File: tb/tb_rmii_tx_serializer.sv
// Bench for rmii_tx_serializer with a short preamble and gap: sweeps payload
// lengths back to back and truncates frames at every byte position.
module tb_rmii_tx_serializer;
    localparam int P = 3;
    localparam int G = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = 8'hFF;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b1;
    logic       in_ready;
    logic [1:0] txd;
    logic       tx_en;
    logic       underrun;

    int checks = 0;
    int errors = 0;

    rmii_tx_serializer #(.PRE_LEN(P), .GAP_CLOCKS(G)) dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .txd(txd), .tx_en(tx_en),
        .underrun(underrun)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] pay(input int seed, input int i);
        return 8'((seed * 29 + i * 71 + 3) ^ (i << 3));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Drive one frame of n bytes, offering only the first nv of them, and
    // compare everything seen on the PHY side against the computed stream.
    task automatic run_frame(input int n, input int nv, input int seed,
                             input bit chk_gap, input bit fresh);
        logic [1:0] cap[$];
        int idx = 0, pre_idle = 0, cyc = 0, ur = 0, ur_bad = 0;
        int err_idle = 0, err_rdy = 0, m, pre_bad = 0, pay_bad = 0;
        bit acc = 0, started = 0, done = 0, exp_rdy;
        m = (nv < n) ? nv : n;
        while (!done) begin
            @(negedge clk);
            cyc++;
            if (cyc > 4000) begin
                check(0, "R3", "frame never ended", cyc, 4000);
                break;
            end
            if (!tx_en && txd != 2'b00) err_idle++;
            if (tx_en) begin
                cap.push_back(txd);
                started = 1;
            end else if (started) begin
                done = 1;
            end else begin
                pre_idle++;
            end
            if (underrun) begin
                if (done) ur++;
                else ur_bad++;
            end
            exp_rdy = 0;
            if (tx_en) begin
                int pos = cap.size() - 1;
                int b = pos / 4;
                exp_rdy = (pos % 4 == 3) && (b >= P) && ((b - P - 1) < (n - 1));
            end
            if (in_ready !== exp_rdy) err_rdy++;
            if (acc) idx++;
            in_valid = started ? ((idx < nv) && (idx < n)) : 1'b1;
            in_data  = in_valid ? pay(seed, idx) : 8'hFF;
            in_last  = in_valid ? (idx == n - 1) : 1'b1;
            acc      = in_valid && in_ready;
        end
        // R3 total enabled length
        check(cap.size() == 4 * (P + 1 + m), "R3", "enabled cycles",
              cap.size(), 4 * (P + 1 + m));
        for (int b = 0; b < P + 1 + m && 4 * b + 3 < cap.size(); b++) begin
            logic [7:0] got = {cap[4*b+3], cap[4*b+2], cap[4*b+1], cap[4*b]};
            logic [7:0] want = (b < P) ? 8'h55 : (b == P) ? 8'hD5 : pay(seed, b - P - 1);
            if (got != want) begin
                if (b <= P) pre_bad++;
                else pay_bad++;
                $display("FAIL %s byte %0d: actual %0d expected %0d",
                         (b <= P) ? "R2" : "R3", b, got, want);
            end
        end
        checks++; if (pre_bad != 0) errors++;   // R2 preamble and delimiter
        checks++; if (pay_bad != 0) errors++;   // R3 payload order and dibit order
        check(err_idle == 0, "R4", "nonzero idle dibits", err_idle, 0);
        check(err_rdy == 0, "R5", "ready pattern mismatches", err_rdy, 0);
        check(ur == ((nv < n) ? 1 : 0), "R8", "underrun at frame end", ur, (nv < n) ? 1 : 0);
        check(ur_bad == 0, "R8", "stray underrun cycles", ur_bad, 0);
        if (chk_gap) check(pre_idle + 1 == G, "R6", "idle gap", pre_idle + 1, G);
        if (fresh) check(pre_idle == 1, "R7", "start latency", pre_idle, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        report();
        $finish;
    end

    initial begin
        int low_seen;
        // R1 during reset
        repeat (3) @(negedge clk);
        check(tx_en == 0 && txd == 0 && in_ready == 0 && underrun == 0, "R1",
              "outputs in reset", {tx_en, txd, in_ready, underrun}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_en == 0 && txd == 0 && in_ready == 0 && underrun == 0, "R1",
              "outputs after reset", {tx_en, txd, in_ready, underrun}, 0);
        // R7 and R4: idle with noisy data and no valid starts nothing
        low_seen = 0;
        for (int i = 0; i < 12; i++) begin
            in_data = 8'(i * 37 + 5);
            in_last = i[0];
            @(negedge clk);
            if (tx_en || txd != 0) low_seen++;
        end
        check(low_seen == 0, "R7", "activity without valid", low_seen, 0);
        // R7 first frame right after idle, then back-to-back length sweep
        run_frame(1, 1, 1, 0, 1);
        for (int n = 2; n <= 12; n++) run_frame(n, n, n, 1, 0);
        // R8 truncation at every byte position of a five-byte frame
        for (int k = 0; k < 5; k++) run_frame(5, k, 40 + k, 1, 0);
        // long frame back to back after an underrun
        run_frame(40, 40, 77, 1, 0);
        // R6 idle well beyond the gap, then restart immediately
        for (int i = 0; i < 3 * G; i++) @(negedge clk);
        run_frame(4, 4, 90, 0, 1);
        report();
        $finish;
    end

endmodule